// File: doc/BRIEF.md
# Wait-Aware Phase Clock Stretcher with Bank Byte Capture

This block sits between a free-running CPU phase clock and a CPU that puts the upper byte of its address on the data bus while the phase clock is low. A fast system clock oversamples the phase clock and an active-low ready request through two-flop synchronizers. From these samples the block builds a stretched phase clock.

A ready request that is low during a high phase arms a hold state. The hold state keeps the stretched clock high, which freezes the CPU. The hold state clears only when a later sample sees the phase clock and ready both high. While the phase clock is low, ready is ignored.

The falling edge of the stretched clock, detected in the system-clock domain, loads the bank byte from the data bus. This means the latch never picks up bus contents while the CPU is frozen. A second copy of the stretched clock, meant for the CPU, can be delayed by a selectable number of system-clock cycles, including zero.

Top module: `phase_stretch_top`

## Requirements
- R1: If a synchronized sample shows the phase clock high and ready low, `phi_str` is high in the following system cycle. It stays high until a later sample shows both the phase clock and ready high.
- R2: While the synchronized phase clock is low, the level of `rdy_in` does not change the hold state. With no hold pending, `phi_str` stays low throughout a low phase whatever `rdy_in` does.
- R3: If ready drops and recovers within one high phase, `phi_str` falls with the phase clock in that period, with no stretch.
- R4: If ready is released while the phase clock is low, `phi_str` stays high through that low phase and through the next high phase. It falls with the phase clock at the end of that next high phase.
- R5: With no hold pending, `phi_str` equals `phi_in` delayed by three system-clock cycles (two synchronizer stages plus one output register).
- R6: `bank_out` loads `dbus_in` in the first system cycle in which `phi_str` reads low after being high; the new value is visible one cycle later. At all other times `bank_out` holds its value, including during a whole stretch.
- R7: `phi_cpu` equals `phi_str` delayed by `dly_sel` system-clock cycles, for `dly_sel` from 0 to 7. A value of 0 gives `phi_cpu` equal to `phi_str` in the same cycle.
- R8: While `rst_n` is low, `phi_str`, `phi_cpu` and `bank_out` are all zero and no hold is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Fast system clock that oversamples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| phi_in | input | 1 | Free-running phase clock from the system |
| rdy_in | input | 1 | Ready request, low asks the CPU to wait |
| dbus_in | input | 8 | Data bus carrying the bank byte during the low phase |
| dly_sel | input | 3 | Delay in system cycles applied to the CPU clock copy |
| phi_str | output | 1 | Stretched phase clock |
| phi_cpu | output | 1 | Delayed copy of the stretched clock for the CPU |
| bank_out | output | 8 | Latched bank byte |

## Verification
The hardest case to reach from the ports is a ready release that lands entirely inside a low phase after a hold was armed. To show that the release is ignored until the next high phase, the stimulus has to place ready edges on known slots relative to the phase clock while allowing for the synchronizer latency. The bench therefore drives the inputs one 16-slot phase period at a time, with a per-slot ready pattern. This lets a scenario put a release in a low phase, a short dip inside a high phase, or a wait across several periods. Each cycle the outputs are compared with a cycle-level reference model, and targeted slots are checked per scenario.

// File: rtl/ps_pkg.sv
package ps_pkg;
  typedef enum logic {
    ST_FOLLOW = 1'b0,
    ST_HOLD   = 1'b1
  } hold_st_e;

  localparam int unsigned DEF_BANK_W  = 8;
  localparam int unsigned DEF_DLY_MAX = 7;
  localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ps_hold_ctl.sv
module ps_hold_ctl
  import ps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic phi_s,
  input  logic rdy_s,
  output logic str_q
);
  hold_st_e st_q, st_d;
  logic     str_d;

  // Hold arms or releases only while the sampled phase clock is high.
  always_comb begin
    st_d = st_q;
    if (phi_s) begin
      st_d = rdy_s ? ST_FOLLOW : ST_HOLD;
    end
    str_d = phi_s | (st_d == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_FOLLOW;
      str_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      str_q <= str_d;
    end
  end

  // R1: a wait seen during a high phase keeps the output high next cycle
  a_r1_wait_holds_high: assert property (@(posedge clk) disable iff (!rst_n)
    (phi_s && !rdy_s) |=> str_q);

  // R1: with both high the hold is released
  a_r1_release_both_high: assert property (@(posedge clk) disable iff (!rst_n)
    (phi_s && rdy_s) |=> (st_q == ST_FOLLOW));

  // R2: ready is ignored while the sampled phase clock is low
  a_r2_low_phase_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !phi_s |=> (st_q == $past(st_q)));

  // R5: no hold and low phase gives a low output
  a_r5_follow_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!phi_s && st_q == ST_FOLLOW) |=> !str_q);
endmodule

// File: rtl/ps_bank_cap.sv
module ps_bank_cap #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         str,
  input  logic [W-1:0] dbus,
  output logic [W-1:0] bank_q
);
  logic         prev_q;
  logic         fall;
  logic [W-1:0] bank_d;

  always_comb begin
    fall   = prev_q & ~str;
    bank_d = fall ? dbus : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      bank_q <= '0;
    end else begin
      prev_q <= str;
      bank_q <= bank_d;
    end
  end

  // R6: the latch only changes after a falling edge of the stretched clock
  a_r6_stable_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !(prev_q && !str) |=> $stable(bank_q));

  // R6: a stretched-high clock never reloads the latch
  a_r6_no_load_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q && str) |=> (bank_q == $past(bank_q)));
endmodule

// File: rtl/ps_tap_delay.sv
module ps_tap_delay #(
  parameter int unsigned DLY_MAX = 7,
  parameter int unsigned DLY_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [DLY_W-1:0] sel,
  output logic             dout
);
  logic [DLY_MAX-1:0] sh_q, sh_d;
  logic [DLY_MAX:0]   taps;

  for (genvar i = 0; i < int'(DLY_MAX); i++) begin : g_stage
    if (i == 0) begin : g_first
      assign sh_d[i] = din;
    end else begin : g_rest
      assign sh_d[i] = sh_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign taps = {sh_q, din};
  assign dout = taps[sel];
endmodule

// File: rtl/phase_stretch_top.sv
module phase_stretch_top
  import ps_pkg::*;
#(
  parameter int unsigned BANK_W  = DEF_BANK_W,
  parameter int unsigned DLY_MAX = DEF_DLY_MAX,
  parameter int unsigned SYNC_N  = DEF_SYNC,
  parameter int unsigned DLY_W   = $clog2(DLY_MAX + 1)
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic              phi_in,
  input  logic              rdy_in,
  input  logic [BANK_W-1:0] dbus_in,
  input  logic [DLY_W-1:0]  dly_sel,
  output logic              phi_str,
  output logic              phi_cpu,
  output logic [BANK_W-1:0] bank_out
);
  logic phi_s, rdy_s;

  ps_sync #(.STAGES(SYNC_N), .W(2)) u_sync (
    .clk   (sys_clk),
    .rst_n (rst_n),
    .d     ({phi_in, rdy_in}),
    .q     ({phi_s, rdy_s})
  );

  ps_hold_ctl u_hold (
    .clk   (sys_clk),
    .rst_n (rst_n),
    .phi_s (phi_s),
    .rdy_s (rdy_s),
    .str_q (phi_str)
  );

  ps_bank_cap #(.W(BANK_W)) u_bank (
    .clk    (sys_clk),
    .rst_n  (rst_n),
    .str    (phi_str),
    .dbus   (dbus_in),
    .bank_q (bank_out)
  );

  ps_tap_delay #(.DLY_MAX(DLY_MAX), .DLY_W(DLY_W)) u_dly (
    .clk   (sys_clk),
    .rst_n (rst_n),
    .din   (phi_str),
    .sel   (dly_sel),
    .dout  (phi_cpu)
  );

  // R7: a one-cycle setting gives the previous stretched value
  a_r7_one_tap: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (dly_sel == DLY_W'(1) && $past(dly_sel) == DLY_W'(1)) |-> (phi_cpu == $past(phi_str)));

  // R8: outputs are cleared while reset is held
  always_comb begin
    if (!rst_n) begin
      a_r8_reset_clear: assert (phi_str == 1'b0 && phi_cpu == 1'b0 && bank_out == '0);
    end
  end
endmodule

// File: tb/phase_stretch_top_test.sv
`timescale 1ns/1ps
module phase_stretch_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       phi_in, rdy_in;
  logic [7:0] dbus_in;
  logic [2:0] dly_sel;
  logic       phi_str, phi_cpu;
  logic [7:0] bank_out;

  int n_chk  = 0;
  int n_fail = 0;
  int per_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phase_stretch_top uut (
    .sys_clk (clk), .rst_n (rst_n), .phi_in (phi_in), .rdy_in (rdy_in),
    .dbus_in (dbus_in), .dly_sel (dly_sel), .phi_str (phi_str),
    .phi_cpu (phi_cpu), .bank_out (bank_out)
  );

  // Cycle-level reference built from the requirements
  logic       m_p1, m_p2, m_r1, m_r2, m_hold, m_str, m_prev;
  logic [7:0] m_bank;
  logic [6:0] m_hist;
  logic [7:0] m_taps;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 <= 0; m_p2 <= 0; m_r1 <= 0; m_r2 <= 0; m_hold <= 0;
      m_str <= 0; m_prev <= 0; m_bank <= '0; m_hist <= '0;
    end else begin
      m_p1 <= phi_in; m_p2 <= m_p1;
      m_r1 <= rdy_in; m_r2 <= m_r1;
      if (m_p2) m_hold <= !m_r2;
      m_str  <= m_p2 ? 1'b1 : m_hold;
      m_prev <= m_str;
      if (m_prev && !m_str) m_bank <= dbus_in;
      m_hist <= {m_hist[5:0], m_str};
    end
  end
  assign m_taps = {m_hist, m_str};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_cmp();
    chk(phi_str == m_str, "R5 phi_str vs model", phi_str, m_str);
    chk(phi_cpu == m_taps[dly_sel], "R7 phi_cpu vs model", phi_cpu, m_taps[dly_sel]);
    chk(bank_out == m_bank, "R6 bank_out vs model", bank_out, m_bank);
  endtask

  // One phase period of 16 slots: high in slots 0..7
  task automatic drive_period(input logic [15:0] rdy_pat,
                              output logic [15:0] obs, output logic [15:0] obs_cpu,
                              output int id);
    id = per_cnt;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      model_cmp();
      obs[k]     = phi_str;
      obs_cpu[k] = phi_cpu;
      phi_in  = (k < 8);
      rdy_in  = rdy_pat[k];
      dbus_in = {4'(per_cnt), 4'(k)};
    end
    per_cnt++;
  endtask

  task automatic t_normal();
    logic [15:0] o, oc; int id;
    drive_period(16'hFFFF, o, oc, id);
    drive_period(16'hFFFF, o, oc, id);
    chk(o[5] == 1'b1, "R5 follows high", o[5], 1);
    chk(o[12] == 1'b0, "R5 follows low", o[12], 0);
    @(negedge clk);
    model_cmp();
    chk(bank_out == {4'(id), 4'hB}, "R6 bank after fall", bank_out, {4'(id), 4'hB});
    // R2: ready toggling in the low phase with no hold pending
    drive_period(16'b0101_0101_1111_1111, o, oc, id);
    chk(o[12] == 1'b0, "R2 low phase ready toggle", o[12], 0);
    chk(o[14] == 1'b0, "R2 low phase ready toggle late", o[14], 0);
    drive_period(16'hFFFF, o, oc, id);
    chk(o[1] == 1'b0, "R2 next period start", o[1], 0);
  endtask

  task automatic t_wait();
    logic [15:0] o, oc; int id; logic [7:0] b1;
    drive_period(16'h0000, o, oc, id);
    chk(o[12] == 1'b1, "R1 stretch first period", o[12], 1);
    b1 = bank_out;
    drive_period(16'h0000, o, oc, id);
    chk(o == 16'hFFFF, "R1 stretch whole period", o, 16'hFFFF);
    drive_period(16'h0000, o, oc, id);
    chk(o == 16'hFFFF, "R1 stretch third period", o, 16'hFFFF);
    chk(bank_out == b1, "R6 bank frozen during stretch", bank_out, b1);
    drive_period(16'hFFFF, o, oc, id);
    chk(o[1] == 1'b1, "R1 still high before release", o[1], 1);
    chk(o[12] == 1'b0, "R1 released after both high", o[12], 0);
    @(negedge clk);
    model_cmp();
    chk(bank_out == {4'(id), 4'hB}, "R6 bank loads after release", bank_out, {4'(id), 4'hB});
  endtask

  task automatic t_glitch();
    logic [15:0] o, oc; int id;
    drive_period(16'hFFE3, o, oc, id);
    chk(o[11] == 1'b0, "R3 short dip no stretch", o[11], 0);
    chk(o[12] == 1'b0, "R3 short dip low phase", o[12], 0);
    drive_period(16'hFFFF, o, oc, id);
  endtask

  task automatic t_release_low();
    logic [15:0] o, oc; int id;
    drive_period(16'hFC00, o, oc, id);
    chk(o[12] == 1'b1, "R4 held in low phase", o[12], 1);
    chk(o[15] == 1'b1, "R4 release in low phase ignored", o[15], 1);
    drive_period(16'hFFFF, o, oc, id);
    chk(o[1] == 1'b1, "R4 still high into next period", o[1], 1);
    chk(o[9] == 1'b1, "R4 high through next high phase", o[9], 1);
    chk(o[12] == 1'b0, "R4 falls after next high phase", o[12], 0);
  endtask

  task automatic t_delay();
    logic [15:0] o, oc; int id;
    dly_sel = 3'd0;
    drive_period(16'hFFFF, o, oc, id);
    drive_period(16'hFFFF, o, oc, id);
    chk(oc == o, "R7 zero delay", oc, o);
    dly_sel = 3'd3;
    drive_period(16'hFFFF, o, oc, id);
    drive_period(16'hFFFF, o, oc, id);
    chk(oc[12] == 1'b1, "R7 delay 3 high", oc[12], 1);
    chk(oc[14] == 1'b0, "R7 delay 3 low", oc[14], 0);
    dly_sel = 3'd7;
    drive_period(16'hFFFF, o, oc, id);
    drive_period(16'hFFFF, o, oc, id);
    chk(oc[15] == 1'b1, "R7 delay 7 high", oc[15], 1);
    chk(oc[9] == 1'b0, "R7 delay 7 low", oc[9], 0);
    dly_sel = 3'd0;
  endtask

  initial begin
    rst_n = 1'b0; phi_in = 1'b0; rdy_in = 1'b1; dbus_in = 8'h5A; dly_sel = 3'd0;
    repeat (4) @(negedge clk);
    phi_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(phi_str == 1'b0 && phi_cpu == 1'b0 && bank_out == 8'h00,
        "R8 reset state", {phi_str, phi_cpu, bank_out}, 0);
    phi_in = 1'b0;
    rst_n = 1'b1;
    t_normal();
    t_wait();
    t_glitch();
    t_release_low();
    t_delay();
    t_normal();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule